// File: doc/BRIEF.md
# Triggered Frame Sample Counter

This block decides which A/D sample strobes of a streaming acquisition front end are passed on as FIFO write enables. A frame begins on a trigger taken from one of three selectable sources: an internal timer tick, an external digital line, or the output of an external analog comparator. Every source has the same effect. Once a frame begins, each sample clock enable produces one write strobe, and a programmable down counter ends the frame after the programmed number of samples. The counter then reloads itself for the next trigger and raises a sticky end-of-frame interrupt.

The block is set up through a small register write port. That port sets the frame length, the mode (single-shot or repeating acceptance, and counted or free-running frames) and the trigger source. It also accepts one-cycle commands: clear the interrupt, arm a single-shot capture, and halt a running frame. While a frame runs, further triggers are ignored. The remaining count is always visible on a status output.

Top module: `acq_frame_ctrl`

## Requirements
- R1: After reset `fifo_we`, `frame_irq` and `frame_busy` are 0, and `count_left` equals 2^CW because the reset frame length is 0.
- R2: A frame length N of 1 to 2^CW-1 is written at address 0 in bits [CW-1:0], and the value 0 stands for 2^CW samples. While idle, `count_left` shows the decoded length starting one cycle after the write.
- R3: `fifo_we` is high only in a cycle where `frame_busy` and `smp_ce` are both high. A sample enable that arrives in the same cycle as the accepted trigger is not written, because `frame_busy` rises one edge after the trigger is accepted.
- R4: A counted frame issues exactly N write strobes. `count_left` drops by one on each strobe, and `frame_busy` falls at the edge that takes the Nth strobe.
- R5: A trigger that arrives while `frame_busy` is high is ignored, including one in the cycle of the last strobe. It never adds samples and never starts a second frame.
- R6: When a frame ends, `count_left` reloads the programmed length, so another trigger runs another frame of the same length with no rewrite. A length written during a frame takes effect only for the next frame.
- R7: `frame_irq` is set at the edge that ends a counted frame and stays set until a write at address 2 with bit 0 set. If the clear and a frame end fall in the same cycle, the set wins.
- R8: Mode bit 0 at address 1 selects repeating acceptance (1) or single-shot acceptance (0). In single-shot acceptance a trigger is taken only after an arm command (address 2, bit 1), and the trigger it takes disarms the block.
- R9: Mode bit 1 at address 1 makes frames free-running. Such a frame never ends by count, `count_left` holds, and the frame stops only on a halt command (address 2, bit 2). A halt ends any frame without setting `frame_irq`.
- R10: Mode bits [3:2] at address 1 select the trigger source: 0 internal tick, 1 external digital, 2 external analog, 3 none. Only a rising edge triggers, and a held level gives one trigger. An internal tick makes `frame_busy` rise one edge later. An external edge passes through SYNC_STAGES flops plus an edge flop, so `frame_busy` rises SYNC_STAGES+1 edges after the pin rises.
- R11: Edges on trigger sources that are not selected have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address (0 length, 1 mode, 2 command) |
| cfg_wdata | input | DATA_W | Register write data |
| tick_int | input | 1 | Internal timer trigger, synchronous |
| trig_dig_in | input | 1 | External digital trigger, asynchronous |
| trig_ana_in | input | 1 | External comparator trigger, asynchronous |
| smp_ce | input | 1 | A/D sample clock enable |
| fifo_we | output | 1 | Gated FIFO write strobe |
| frame_irq | output | 1 | Sticky end-of-frame interrupt flag |
| frame_busy | output | 1 | Frame in progress |
| count_left | output | CW+1 | Samples remaining, or the reloaded length while idle |

## Verification
A wrong remaining count shows in the same cycle on `count_left`. It then changes the number of `fifo_we` strobes in the frame, which is visible at the edge where `frame_busy` should fall. A broken lockout or broken single-shot arming shows as a second frame of strobes within a cycle of the stray trigger. A synchronizer of the wrong depth moves the rise of `frame_busy` by whole cycles. The bench compares every output with a behavioural model on every cycle, so any of these faults shows up no more than one cycle after it occurs.

// File: rtl/acq_frame_pkg.sv
package acq_frame_pkg;
   typedef enum logic [1:0] {
      SRC_TIMER   = 2'd0,
      SRC_EXT_DIG = 2'd1,
      SRC_EXT_ANA = 2'd2,
      SRC_NONE    = 2'd3
   } trig_src_e;

   typedef struct packed {
      logic      cont;
      logic      free_run;
      trig_src_e src;
   } mode_t;

   localparam int REG_LENGTH = 0;
   localparam int REG_MODE   = 1;
   localparam int REG_CMD    = 2;

   localparam int MODE_CONT_BIT = 0;
   localparam int MODE_FREE_BIT = 1;
   localparam int MODE_SRC_LSB  = 2;

   localparam int CMD_CLR_BIT  = 0;
   localparam int CMD_ARM_BIT  = 1;
   localparam int CMD_HALT_BIT = 2;
endpackage

// File: rtl/acq_edge_sync.sv
module acq_edge_sync #(
   parameter int STAGES  = 2,
   parameter bit SYNC_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("acq_edge_sync: STAGES must be at least 2");
   end

   if (SYNC_EN) begin : g_sync
      logic [STAGES:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-1:0], din};
      end
      assign rise = chain[STAGES-1] & ~chain[STAGES];
   end else begin : g_direct
      logic last;
      always_ff @(posedge clk) begin
         if (!rst_n) last <= 1'b0;
         else        last <= din;
      end
      assign rise = din & ~last;
   end
endmodule

// File: rtl/acq_trig_front.sv
module acq_trig_front
   import acq_frame_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick_int,
   input  logic      trig_dig_in,
   input  logic      trig_ana_in,
   input  trig_src_e src,
   output logic      trig_evt
);
   localparam int NSRC = 3;
   logic [NSRC-1:0] pins;
   logic [NSRC-1:0] rises;

   assign pins = {trig_ana_in, trig_dig_in, tick_int};

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      acq_edge_sync #(
         .STAGES (SYNC_STAGES),
         .SYNC_EN(i != 0)
      ) u_edge (
         .clk (clk),
         .rst_n(rst_n),
         .din (pins[i]),
         .rise(rises[i])
      );
   end

   always_comb begin
      unique case (src)
         SRC_TIMER:   trig_evt = rises[0];
         SRC_EXT_DIG: trig_evt = rises[1];
         SRC_EXT_ANA: trig_evt = rises[2];
         default:     trig_evt = 1'b0;
      endcase
   end
endmodule

// File: rtl/acq_frame_regs.sv
module acq_frame_regs
   import acq_frame_pkg::*;
#(
   parameter int CW     = 24,
   parameter int ADDR_W = 2,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              consume,
   input  logic              done,
   output logic [CW-1:0]     count_q,
   output mode_t             mode_q,
   output logic              clr_p,
   output logic              arm_p,
   output logic              halt_p,
   output logic              armed_q,
   output logic              irq_q
);
   if (DATA_W < CW) begin : g_bad_data
      $error("acq_frame_regs: DATA_W must cover CW");
   end
   if (DATA_W < MODE_SRC_LSB + 2) begin : g_bad_mode
      $error("acq_frame_regs: DATA_W too narrow for mode fields");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("acq_frame_regs: ADDR_W must be at least 2");
   end

   logic wr_len, wr_mode, wr_cmd;
   assign wr_len  = cfg_we && (cfg_addr == ADDR_W'(REG_LENGTH));
   assign wr_mode = cfg_we && (cfg_addr == ADDR_W'(REG_MODE));
   assign wr_cmd  = cfg_we && (cfg_addr == ADDR_W'(REG_CMD));

   assign clr_p  = wr_cmd & cfg_wdata[CMD_CLR_BIT];
   assign arm_p  = wr_cmd & cfg_wdata[CMD_ARM_BIT];
   assign halt_p = wr_cmd & cfg_wdata[CMD_HALT_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         mode_q  <= '{cont: 1'b0, free_run: 1'b0, src: SRC_TIMER};
      end else begin
         if (wr_len) count_q <= cfg_wdata[CW-1:0];
         if (wr_mode) begin
            mode_q.cont     <= cfg_wdata[MODE_CONT_BIT];
            mode_q.free_run <= cfg_wdata[MODE_FREE_BIT];
            mode_q.src      <= trig_src_e'(cfg_wdata[MODE_SRC_LSB +: 2]);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         armed_q <= (armed_q & ~consume) | arm_p;
         if (done)       irq_q <= 1'b1;
         else if (clr_p) irq_q <= 1'b0;
      end
   end
endmodule

// File: rtl/acq_frame_cnt.sv
module acq_frame_cnt #(
   parameter int CW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          smp_ce,
   input  logic          free_run,
   input  logic          halt,
   input  logic [CW-1:0] reload_cnt,
   output logic          running,
   output logic [CW:0]   left,
   output logic          done
);
   if (CW < 2) begin : g_bad_cw
      $error("acq_frame_cnt: CW must be at least 2");
   end

   localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};
   localparam logic [CW:0] ONE  = {{CW{1'b0}}, 1'b1};

   logic [CW:0] rel;
   logic        last;

   assign rel  = (reload_cnt == '0) ? FULL : {1'b0, reload_cnt};
   assign last = (left == ONE);
   assign done = running & smp_ce & ~free_run & last & ~halt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         left    <= FULL;
      end else if (halt || done) begin
         running <= 1'b0;
         left    <= rel;
      end else if (running) begin
         if (smp_ce && !free_run) left <= left - ONE;
      end else begin
         left <= rel;
         if (start) running <= 1'b1;
      end
   end
endmodule

// File: rtl/acq_frame_ctrl.sv
module acq_frame_ctrl
   import acq_frame_pkg::*;
#(
   parameter int CW          = 24,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              tick_int,
   input  logic              trig_dig_in,
   input  logic              trig_ana_in,
   input  logic              smp_ce,
   output logic              fifo_we,
   output logic              frame_irq,
   output logic              frame_busy,
   output logic [CW:0]       count_left
);
   mode_t         mode_q;
   logic [CW-1:0] count_q;
   logic          clr_p, arm_p, halt_p, armed_q;
   logic          trig_evt, start, done, running;
   logic          free_run_q;

   assign free_run_q = mode_q.free_run;
   assign start = trig_evt & ~running & (mode_q.cont | armed_q) & ~halt_p;

   acq_frame_regs #(.CW(CW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .consume  (start & ~mode_q.cont),
      .done     (done),
      .count_q  (count_q),
      .mode_q   (mode_q),
      .clr_p    (clr_p),
      .arm_p    (arm_p),
      .halt_p   (halt_p),
      .armed_q  (armed_q),
      .irq_q    (frame_irq)
   );

   acq_trig_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_int   (tick_int),
      .trig_dig_in(trig_dig_in),
      .trig_ana_in(trig_ana_in),
      .src        (mode_q.src),
      .trig_evt   (trig_evt)
   );

   acq_frame_cnt #(.CW(CW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .smp_ce    (smp_ce),
      .free_run  (free_run_q),
      .halt      (halt_p),
      .reload_cnt(count_q),
      .running   (running),
      .left      (count_left),
      .done      (done)
   );

   assign frame_busy = running;
   assign fifo_we    = running & smp_ce;
endmodule

// File: rtl/acq_frame_ctrl_chk.sv
module acq_frame_ctrl_chk #(
   parameter int CW = 24
) (
   input logic        clk,
   input logic        rst_n,
   input logic        fifo_we,
   input logic        frame_busy,
   input logic        frame_irq,
   input logic [CW:0] count_left,
   input logic        free_run,
   input logic        halt,
   input logic        clr
);
   // R3: no write strobe outside a frame
   p_idle_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_busy |-> !fifo_we);

   // R4: each strobe in a counted frame takes one off the count
   p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_busy && fifo_we && !free_run && !halt && count_left > 1)
      |=> (count_left == $past(count_left) - 1'b1));

   // R5: while a frame keeps running the count never grows
   p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_busy && $past(frame_busy)) |-> (count_left <= $past(count_left)));

   // R7: the last strobe ends the frame and raises the flag
   p_end_sets_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_busy && fifo_we && !free_run && !halt && count_left == 1)
      |=> (frame_irq && !frame_busy));

   // R7: the flag holds until cleared
   p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_irq && !clr) |=> frame_irq);

   // R2: the remaining count is never zero
   p_left_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count_left != '0);

   // R9: a free-running frame stops only on halt
   p_free_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_busy && free_run && !halt) |=> frame_busy);
endmodule

bind acq_frame_ctrl acq_frame_ctrl_chk #(.CW(CW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fifo_we   (fifo_we),
   .frame_busy(frame_busy),
   .frame_irq (frame_irq),
   .count_left(count_left),
   .free_run  (free_run_q),
   .halt      (halt_p),
   .clr       (clr_p)
);

// File: tb/test_acq_frame_ctrl.sv
module test_acq_frame_ctrl;
   localparam int CW = 24, SYNC = 2, AW = 2, DW = 32;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic          tick_int = 1'b0, trig_dig_in = 1'b0, trig_ana_in = 1'b0;
   logic          smp_ce = 1'b1;
   logic          fifo_we, frame_irq, frame_busy;
   logic [CW:0]   count_left;
   bit            ce_mode = 1'b0;

   acq_frame_ctrl #(.CW(CW), .SYNC_STAGES(SYNC), .ADDR_W(AW), .DATA_W(DW)) i_acq_frame_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .tick_int(tick_int), .trig_dig_in(trig_dig_in), .trig_ana_in(trig_ana_in),
      .smp_ce(smp_ce), .fifo_we(fifo_we), .frame_irq(frame_irq),
      .frame_busy(frame_busy), .count_left(count_left));

   int checks = 0, fails = 0, strobes = 0;

   task automatic check(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   bit m_run, m_irq, m_armed, m_cont, m_free, m_ip;
   int m_left, m_cnt, m_src;
   bit hd[SYNC+1];
   bit ha[SYNC+1];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_irq = 0; m_armed = 0; m_cont = 0; m_free = 0; m_ip = 0;
         m_src = 0; m_cnt = 0; m_left = 1 << CW;
         for (int k = 0; k <= SYNC; k++) begin hd[k] = 0; ha[k] = 0; end
      end else begin
         bit ei, ed, ea, sel, acc, done, halt, clr, arm;
         int rel;
         ei = tick_int && !m_ip;
         ed = hd[SYNC-1] && !hd[SYNC];
         ea = ha[SYNC-1] && !ha[SYNC];
         case (m_src)
            0: sel = ei;
            1: sel = ed;
            2: sel = ea;
            default: sel = 0;
         endcase
         halt = cfg_we && cfg_addr == 2 && cfg_wdata[2];
         clr  = cfg_we && cfg_addr == 2 && cfg_wdata[0];
         arm  = cfg_we && cfg_addr == 2 && cfg_wdata[1];
         rel  = (m_cnt == 0) ? (1 << CW) : m_cnt;
         acc  = sel && !m_run && (m_cont || m_armed) && !halt;
         done = m_run && smp_ce && !m_free && m_left == 1 && !halt;
         if (halt || done) begin m_run = 0; m_left = rel; end
         else if (m_run) begin if (smp_ce && !m_free) m_left--; end
         else begin m_left = rel; if (acc) m_run = 1; end
         if (done) m_irq = 1; else if (clr) m_irq = 0;
         m_armed = (m_armed && !(acc && !m_cont)) || arm;
         for (int k = SYNC; k > 0; k--) begin hd[k] = hd[k-1]; ha[k] = ha[k-1]; end
         hd[0] = trig_dig_in; ha[0] = trig_ana_in; m_ip = tick_int;
         if (cfg_we && cfg_addr == 0) m_cnt = int'(cfg_wdata[CW-1:0]);
         if (cfg_we && cfg_addr == 1) begin
            m_cont = cfg_wdata[0]; m_free = cfg_wdata[1]; m_src = int'(cfg_wdata[3:2]);
         end
      end
   end

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         check("R3", "fifo_we", fifo_we, longint'(m_run && smp_ce));
         check("R5", "frame_busy", frame_busy, m_run);
         check("R4", "count_left", count_left, m_left);
         check("R7", "frame_irq", frame_irq, m_irq);
         if (fifo_we) strobes++;
      end
   end

   always @(negedge clk) smp_ce <= ce_mode ? ~smp_ce : 1'b1;

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic sample;
      @(negedge clk); #3;
   endtask
   task automatic wr(int a, logic [DW-1:0] d);
      @(negedge clk); cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = d;
      @(negedge clk); cfg_we = 0;
   endtask
   task automatic pulse_int;
      @(negedge clk); tick_int = 1;
      @(negedge clk); tick_int = 0;
   endtask
   task automatic pulse_ana;
      @(negedge clk); trig_ana_in = 1;
      @(negedge clk); trig_ana_in = 0;
   endtask

   initial begin
      #(8 * 100000);
      fails++;
      $display("FAIL R4 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1;
      #3;
      check("R1", "reset fifo_we", fifo_we, 0);
      check("R1", "reset irq", frame_irq, 0);
      check("R1", "reset busy", frame_busy, 0);
      check("R1", "reset count_left", count_left, 1 << CW);

      wr(1, 32'h1);                 // repeating, internal source
      wr(0, 32'd5);
      sample;
      check("R2", "idle length 5", count_left, 5);

      strobes = 0;
      pulse_int; idle(3); pulse_int; idle(12); #3;
      check("R4", "strobes in frame", strobes, 5);
      check("R5", "mid-frame trigger ignored", frame_busy, 0);
      check("R6", "reloaded length", count_left, 5);
      check("R7", "irq after frame", frame_irq, 1);
      wr(2, 32'h1);
      sample;
      check("R7", "irq cleared", frame_irq, 0);

      ce_mode = 1; strobes = 0;
      pulse_int; idle(20); #3;
      check("R6", "second frame no rewrite", strobes, 5);
      ce_mode = 0; idle(2);

      strobes = 0;
      pulse_int; idle(2); wr(0, 32'd3); idle(10); #3;
      check("R6", "length change mid-frame", strobes, 5);
      check("R2", "new idle length", count_left, 3);
      strobes = 0;
      pulse_int; idle(8); #3;
      check("R6", "next frame uses new length", strobes, 3);

      wr(0, 32'd0); sample;
      check("R2", "zero means full range", count_left, 1 << CW);
      wr(0, 32'd4);

      wr(1, 32'h0); wr(2, 32'h1);   // single-shot
      strobes = 0;
      pulse_int; idle(8); #3;
      check("R8", "unarmed trigger", strobes, 0);
      wr(2, 32'h2);
      pulse_int; idle(8); #3;
      check("R8", "armed trigger", strobes, 4);
      pulse_int; idle(8); #3;
      check("R8", "disarmed after frame", strobes, 4);

      wr(1, 32'h5);                 // repeating, external digital
      strobes = 0;
      pulse_int; pulse_ana; idle(8); #3;
      check("R11", "other sources ignored", strobes, 0);
      @(negedge clk); trig_dig_in = 1;
      sample;
      check("R10", "busy one edge after pin", frame_busy, 0);
      sample;
      check("R10", "busy two edges after pin", frame_busy, 0);
      sample;
      check("R10", "busy three edges after pin", frame_busy, 1);
      idle(20); #3;
      check("R10", "held level one frame", strobes, 4);
      @(negedge clk); trig_dig_in = 0;

      wr(1, 32'h9);                 // external analog
      strobes = 0;
      @(negedge clk); trig_ana_in = 1;
      idle(20); #3;
      check("R10", "analog source frame", strobes, 4);
      @(negedge clk); trig_ana_in = 0;

      wr(1, 32'hD);                 // no source
      strobes = 0;
      pulse_int; pulse_ana; idle(10); #3;
      check("R11", "source none", strobes, 0);

      wr(2, 32'h1);
      wr(1, 32'h3);                 // repeating, free-running, internal
      pulse_int;
      sample;
      strobes = 0;
      idle(40); #3;
      check("R9", "free-run strobes", strobes, 40);
      check("R9", "free-run still busy", frame_busy, 1);
      check("R9", "free-run count held", count_left, 4);
      wr(2, 32'h4);
      sample;
      check("R9", "halt stops frame", frame_busy, 0);
      check("R9", "halt sets no irq", frame_irq, 0);

      idle(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule